// File: doc/BRIEF.md
# Time-Multiplexed Single-MAC FIR Filter

This block is a finite-impulse-response filter clocked by the fast system clock and advanced by a one-cycle sample strobe. No slow clock is derived: each strobe shifts one 8-bit signed sample into the delay line, clears the accumulator and starts a tap walk. During the walk, one multiply-accumulate unit adds one coefficient-times-sample product per clock. The system clock runs 128 times faster than the sample rate. With at most 64 taps, the walk ends well inside one sample interval.

The coefficient table is fixed when the design is elaborated and is computed from a formula. After the last tap, the accumulator is rounded, shifted down and clamped to a 16-bit result, and a one-cycle valid pulse marks the new value. A strobe that arrives while a walk is still in progress abandons that walk and restarts it with the new sample. It also sets a sticky overrun flag that only reset clears.

The sequencer has three states:
- `ST_IDLE` waits for a strobe.
- `ST_MAC` steps through the taps.
- `ST_EMIT` registers the output.

It has these transitions:
- `IDLE->MAC`, `MAC->MAC`, `EMIT->MAC` on a strobe (the last two also set the overrun flag).
- `MAC->MAC` while taps remain.
- `MAC->EMIT` after the last tap.
- `EMIT->IDLE` when no strobe arrives.

Top module: `fir_shared_mac`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `y_out` is 0 and `y_vld` and `ovr_flag` are 0; the delay line holds zeros.
- R2: With the most recent sample x[n] and older samples x[n-k], the filter computes acc = sum over k = 0..N_TAPS-1 of c[k]*x[n-k]. Samples older than the first one after reset count as 0. The coefficients are c[k] = ((37*k + 11) mod 2^COEF_W) - 2^(COEF_W-1), and defaults are N_TAPS = 16 and COEF_W = 8.
- R3: `smp_in` is taken only in a cycle where `smp_en` is high; values it carries in other cycles have no effect on any later output.
- R4: `y_vld` is high for exactly one cycle, N_TAPS+1 clock edges after the edge that captured the strobe, and `y_out` takes its new value on that same edge.
- R5: The output is floor((acc + 2^(SHIFT-1)) / 2^SHIFT) (round half up, SHIFT = 2 by default), computed on an accumulator wide enough that no tap sum can overflow.
- R6: A rounded value above 32767 is output as 32767; below -32768 it is output as -32768.
- R7: `y_out` holds its value in every cycle in which `y_vld` is low.
- R8: A strobe while a walk or its emit cycle is pending discards that result (no `y_vld` for it), shifts the new sample in, and restarts the walk. It also sets `ovr_flag`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | One-cycle sample strobe |
| smp_in | input | 8 | Signed input sample (converter MSBs) |
| y_out | output | 16 | Rounded, saturated filter output |
| y_vld | output | 1 | One-cycle pulse when `y_out` is new |
| ovr_flag | output | 1 | Sticky: a strobe arrived mid-walk |

## Verification
The bound checker watches the following on every cycle:
- `y_vld` is one cycle wide.
- `y_vld` appears exactly N_TAPS+1 edges after the most recent strobe, so an abandoned walk can never emit.
- `y_out` stays still between pulses.
- The overrun flag is sticky and rises only on a strobe.

Only the bench scenarios can show that the numeric results are right: the convolution value, the coefficient formula, the round-half-up step, the clamping at both rails, and the fact that `smp_in` is ignored between strobes. Each of these is checked against an independent arithmetic model for impulse, step, random, idle and extreme-pattern inputs.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_EMIT = 2'd2
    } seq_state_t;

    // Coefficient k of a table with cw-bit signed entries.
    function automatic int tap_coef(int k, int cw);
        int span;
        span = 1 << cw;
        return ((k * 37 + 11) % span) - (span >> 1);
    endfunction

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
    parameter int N_TAPS = 16,
    parameter int SMP_W  = 8,
    parameter int IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic signed [SMP_W-1:0] rd_smp
);

    logic signed [SMP_W-1:0] stage [N_TAPS];

    for (genvar g = 0; g < N_TAPS; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)        stage[g] <= '0;
                else if (shift_en) stage[g] <= smp_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n)        stage[g] <= '0;
                else if (shift_en) stage[g] <= stage[g-1];
            end
        end
    end

    assign rd_smp = stage[rd_idx];

endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
    parameter int SMP_W  = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     step,
    input  logic signed [SMP_W-1:0]  smp,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [ACC_W-1:0]  acc
);

    localparam int PROD_W = SMP_W + COEF_W;

    logic signed [PROD_W-1:0] prod;

    assign prod = smp * coef;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (step)     acc <= acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
    parameter int ACC_W = 21,
    parameter int OUT_W = 16,
    parameter int SHIFT = 2
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] y
);

    localparam int EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] HALF = EXT_W'((1 << SHIFT) >> 1);
    localparam logic signed [EXT_W-1:0] HI   = EXT_W'((1 << (OUT_W-1)) - 1);
    localparam logic signed [EXT_W-1:0] LO   = EXT_W'(-(1 << (OUT_W-1)));

    logic signed [EXT_W-1:0] biased;
    logic signed [EXT_W-1:0] scaled;

    always_comb begin
        biased = {acc[ACC_W-1], acc} + HALF;
        scaled = biased >>> SHIFT;
        if (scaled > HI)      y = HI[OUT_W-1:0];
        else if (scaled < LO) y = LO[OUT_W-1:0];
        else                  y = scaled[OUT_W-1:0];
    end

endmodule

// File: rtl/fir_shared_mac.sv
module fir_shared_mac #(
    parameter int N_TAPS = 16,
    parameter int SMP_W  = 8,
    parameter int COEF_W = 8,
    parameter int OUT_W  = 16,
    parameter int SHIFT  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic [SMP_W-1:0] smp_in,
    output logic [OUT_W-1:0] y_out,
    output logic             y_vld,
    output logic             ovr_flag
);
    import fir_mac_pkg::*;

    localparam int IDX_W = (N_TAPS > 1) ? $clog2(N_TAPS) : 1;
    localparam int ACC_W = SMP_W + COEF_W + IDX_W + 1;
    localparam logic [IDX_W-1:0] LAST_TAP = IDX_W'(N_TAPS - 1);

    seq_state_t state_q, state_d;
    logic [IDX_W-1:0] tap_q, tap_d;
    logic mac_clr, mac_step, emit;

    logic signed [COEF_W-1:0] coef_tab [N_TAPS];
    logic signed [SMP_W-1:0]  cur_smp;
    logic signed [ACC_W-1:0]  acc;
    logic signed [OUT_W-1:0]  rounded;

    for (genvar g = 0; g < N_TAPS; g++) begin : g_coef
        assign coef_tab[g] = COEF_W'(tap_coef(g, COEF_W));
    end

    fir_tap_line #(.N_TAPS(N_TAPS), .SMP_W(SMP_W), .IDX_W(IDX_W)) u_line (
        .clk(clk), .rst_n(rst_n), .shift_en(smp_en),
        .smp_in(smp_in), .rd_idx(tap_q), .rd_smp(cur_smp)
    );

    fir_mac_unit #(.SMP_W(SMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(mac_clr), .step(mac_step),
        .smp(cur_smp), .coef(coef_tab[tap_q]), .acc(acc)
    );

    fir_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_rnd (
        .acc(acc), .y(rounded)
    );

    // Next-state decode
    always_comb begin
        state_d  = state_q;
        tap_d    = tap_q;
        mac_clr  = 1'b0;
        mac_step = 1'b0;
        emit     = 1'b0;
        if (smp_en) begin
            state_d = ST_MAC;
            tap_d   = '0;
            mac_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_MAC: begin
                    mac_step = 1'b1;
                    if (tap_q == LAST_TAP) state_d = ST_EMIT;
                    else                   tap_d   = tap_q + IDX_W'(1);
                end
                ST_EMIT: begin
                    emit    = 1'b1;
                    state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
        end else begin
            state_q <= state_d;
            tap_q   <= tap_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out    <= '0;
            y_vld    <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            y_vld <= emit;
            if (emit) y_out <= rounded;
            if (smp_en && state_q != ST_IDLE) ovr_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/fir_shared_mac_chk.sv
module fir_shared_mac_chk #(
    parameter int N_TAPS = 16,
    parameter int OUT_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_en,
    input logic [OUT_W-1:0] y_out,
    input logic             y_vld,
    input logic             ovr_flag
);

    logic [7:0] since_en;

    always_ff @(posedge clk) begin
        if (!rst_n)               since_en <= 8'hFF;
        else if (smp_en)          since_en <= 8'd0;
        else if (since_en != 8'hFF) since_en <= since_en + 8'd1;
    end

    assert_vld_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        y_vld |=> !y_vld);

    assert_vld_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        y_vld |-> since_en == 8'(N_TAPS + 1));

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !y_vld |-> $stable(y_out));

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);

    assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(smp_en));

endmodule

bind fir_shared_mac fir_shared_mac_chk #(.N_TAPS(N_TAPS), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
    .y_out(y_out), .y_vld(y_vld), .ovr_flag(ovr_flag)
);

// File: tb/fir_shared_mac_test.sv
module fir_shared_mac_test;

    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0;
    logic [7:0] smp_in = '0;
    logic [15:0] y_out;
    logic       y_vld;
    logic       ovr_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int hist [N];

    fir_shared_mac uut (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_in(smp_in),
        .y_out(y_out), .y_vld(y_vld), .ovr_flag(ovr_flag)
    );

    always #4 clk = ~clk;

    function automatic int coef_ref(int k);
        return ((k * 37 + 11) % 256) - 128;
    endfunction

    function automatic int model_out();
        int s;
        int r;
        s = 0;
        for (int k = 0; k < N; k++) s += coef_ref(k) * hist[k];
        r = (s + 2) >>> 2;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic void model_shift(int x);
        for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        smp_en = 1'b0;
        for (int k = 0; k < N; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 y_out after reset", int'(y_out), 0);
        check("R1 y_vld after reset", int'(y_vld), 0);
        check("R1 ovr_flag after reset", int'(ovr_flag), 0);
    endtask

    // Entered and left at a falling edge.
    task automatic push_and_check(int x, string req);
        int held;
        smp_en = 1'b1;
        smp_in = 8'(x);
        model_shift(x);
        @(negedge clk);
        smp_en = 1'b0;
        smp_in = 8'($urandom);   // garbage between strobes (R3)
        repeat (N) @(negedge clk);
        check("R4 no early valid", int'(y_vld), 0);
        @(negedge clk);
        check("R4 valid after N+1 edges", int'(y_vld), 1);
        check(req, int'($signed(y_out)), model_out());
        held = int'($signed(y_out));
        @(negedge clk);
        check("R4 valid one cycle wide", int'(y_vld), 0);
        check("R7 output held", int'($signed(y_out)), held);
    endtask

    task automatic test_impulse();
        push_and_check(2, "R2 R5 impulse head");
        for (int i = 0; i < N; i++) push_and_check(0, "R2 R5 impulse tail");
        push_and_check(-1, "R2 R5 neg impulse head");
        for (int i = 0; i < N; i++) push_and_check(0, "R2 R5 neg impulse tail");
    endtask

    task automatic test_step();
        for (int i = 0; i < N + 4; i++) push_and_check(100, "R2 step");
    endtask

    task automatic test_random();
        for (int i = 0; i < 40; i++)
            push_and_check(int'($urandom_range(0, 255)) - 128, "R2 R5 random");
    endtask

    task automatic test_saturation();
        for (int j = 0; j < N; j++)
            push_and_check((coef_ref(N - 1 - j) >= 0) ? 127 : -128, "R6 positive ramp");
        check("R6 clamp high", int'($signed(y_out)), 32767);
        for (int j = 0; j < N; j++)
            push_and_check((coef_ref(N - 1 - j) >= 0) ? -128 : 127, "R6 negative ramp");
        check("R6 clamp low", int'($signed(y_out)), -32768);
    endtask

    task automatic test_idle_ignore();
        int held;
        int vld_cnt;
        held = int'($signed(y_out));
        vld_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            smp_in = 8'($urandom);
            @(negedge clk);
            if (y_vld) vld_cnt++;
        end
        check("R3 no output while idle", vld_cnt, 0);
        check("R3 R7 output unchanged while idle", int'($signed(y_out)), held);
        push_and_check(0, "R3 idle inputs ignored");
        push_and_check(5, "R3 idle inputs ignored");
    endtask

    task automatic test_overrun();
        int vld_cnt;
        check("R8 flag clear before overrun", int'(ovr_flag), 0);
        smp_en = 1'b1;
        smp_in = 8'(77);
        model_shift(77);
        @(negedge clk);
        smp_en = 1'b0;
        vld_cnt = 0;
        repeat (5) begin
            @(negedge clk);
            if (y_vld) vld_cnt++;
        end
        smp_en = 1'b1;
        smp_in = 8'(-33);
        model_shift(-33);
        @(negedge clk);
        smp_en = 1'b0;
        check("R8 flag set by mid-walk strobe", int'(ovr_flag), 1);
        repeat (N) begin
            @(negedge clk);
            if (y_vld) vld_cnt++;
        end
        check("R8 abandoned walk emits nothing", vld_cnt, 0);
        @(negedge clk);
        check("R8 restarted walk emits", int'(y_vld), 1);
        check("R8 restarted result", int'($signed(y_out)), model_out());
        @(negedge clk);
        push_and_check(10, "R8 normal after overrun");
        check("R8 flag sticky", int'(ovr_flag), 1);
        do_reset();
        check("R8 flag cleared by reset", int'(ovr_flag), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        test_impulse();
        test_step();
        test_random();
        test_saturation();
        test_idle_ignore();
        test_overrun();
        push_and_check(-50, "R1 R2 fresh history after reset");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule